// File: doc/BRIEF.md
# HDLC Receive Packet Controller

This block takes a serial line bit stream, qualified by a per-bit valid strobe, and recovers HDLC frames from it. It hunts for the opening flag and removes the zero inserted after every run of five ones. It assembles octets least significant bit first. It checks each frame against a CRC-16 frame check sequence and writes the payload bytes into a receive FIFO. The two check bytes are never stored.

A host sees one byte that combines the FIFO occupancy with a status-pending bit. Beside it sits a three-bit code that tells the host how the last frame ended. The host pops bytes through a first-word-fall-through read port and acknowledges the status code. It can program a high-watermark threshold. Two level interrupts, for frame end and for watermark, can each be masked on their own. A soft reset returns everything to the idle, hunting state.

Top module: `hdlc_rx_ctrl`

## Requirements
- R1: A flag is the bit pattern 0x7E, sent least significant bit first (0,1,1,1,1,1,1,0). A flag opens a frame and also closes the frame in progress. Octets between flags are assembled least significant bit first.
- R2: Inside a frame, a 0 that directly follows five consecutive 1s is removed before octet assembly. A 0 that follows exactly six 1s completes a flag.
- R3: The last two octets of a frame are a CRC-16 check sequence (reflected polynomial 0x8408, preset 0xFFFF). If the register over all octets ends at 0xF0B8, the frame ends with code 001, otherwise with code 010. The two check octets never enter the FIFO.
- R4: Payload octets enter the FIFO in arrival order. rd_data shows the oldest octet whenever the FIFO is not empty. A one-cycle rd_en pulse removes that octet.
- R5: avail_stat[6:0] is the FIFO occupancy, saturated at 127. avail_stat[7] is 1 exactly when a frame-end code is pending.
- R6: pkt_status is 000 while no frame end is pending. When a frame ends it takes 001 (good), 010 (CRC error), 011 (aborted) or 100 (overflow), and avail_stat[7] goes to 1. A one-cycle stat_ack pulse returns both to 0.
- R7: Seven consecutive 1s abort the frame. If at least one octet of the frame was received, the code becomes 011. The controller then ignores all bits until the next flag.
- R8: When the FIFO is full, further payload octets are dropped. The frame then ends with code 100, whatever its CRC.
- R9: A frame of fewer than three octets (one payload octet plus two check octets) is discarded without a code and without writing the FIFO.
- R10: irq_hwm is 1 exactly when hwm_ie is 1, hwm_thr is nonzero and the FIFO occupancy is at least hwm_thr.
- R11: irq_end is 1 exactly when end_ie is 1 and a frame-end code is pending.
- R12: A one-cycle soft_rst pulse empties the FIFO, clears the code and the pending bit, and returns the receiver to flag hunting. By the following cycle avail_stat and pkt_status both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous controller reset |
| rx_bit | input | 1 | Serial line bit |
| rx_bit_vld | input | 1 | rx_bit is valid in this cycle |
| rd_en | input | 1 | Pop the oldest FIFO octet |
| rd_data | output | 8 | Oldest FIFO octet |
| avail_stat | output | 8 | Pending flag (bit 7) and saturated occupancy (bits 6:0) |
| pkt_status | output | 3 | Frame-end code |
| stat_ack | input | 1 | Clear the pending code |
| hwm_thr | input | $clog2(FIFO_DEPTH+1) | High-watermark threshold |
| hwm_ie | input | 1 | High-watermark interrupt enable |
| end_ie | input | 1 | Frame-end interrupt enable |
| irq_hwm | output | 1 | High-watermark interrupt |
| irq_end | output | 1 | Frame-end interrupt |

## Verification
The bench builds the controller with FIFO_DEPTH = 256 and STUFF_RUN = 5. A depth of 256 lets one 200-octet frame push the true occupancy past 127, so the saturation of the count field can be seen. A 260-octet frame then fills the FIFO and drops octets, which reaches the overflow code within a few thousand line bits. The stuffing run of five matches the standard flag, so payloads holding 0x7E and 0xFF exercise zero removal across octet boundaries.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
   typedef enum logic [2:0] {
      PS_BUSY   = 3'd0,
      PS_GOOD   = 3'd1,
      PS_CRCERR = 3'd2,
      PS_ABORT  = 3'd3,
      PS_OVF    = 3'd4
   } pkt_code_e;

   localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
   localparam logic [15:0] CRC_POLY_REF = 16'h8408;
   localparam logic [15:0] CRC_GOOD_RES = 16'hF0B8;
endpackage

// File: rtl/hdlc_rx_crc16.sv
module hdlc_rx_crc16 #(
   parameter logic [15:0] POLY = 16'h8408
) (
   input  logic [15:0] crc_in,
   input  logic [7:0]  data_in,
   output logic [15:0] crc_out
);
   always_comb begin
      logic [15:0] c;
      c = crc_in;
      for (int i = 0; i < 8; i++) begin
         if (c[0] ^ data_in[i]) c = (c >> 1) ^ POLY;
         else                   c = c >> 1;
      end
      crc_out = c;
   end
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
   parameter int DEPTH = 256,
   parameter int W     = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_en,
   output logic [W-1:0]  rd_data,
   output logic [CW-1:0] level,
   output logic          full
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_wr, do_rd;

   assign full    = (level == CW'(DEPTH));
   assign do_wr   = wr_en & ~full;
   assign do_rd   = rd_en & (level != '0);
   assign rd_data = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
   import hdlc_rx_pkg::*;
#(
   parameter int STUFF_RUN = 5,
   localparam int OW       = $clog2(STUFF_RUN + 3)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      bit_in,
   input  logic      bit_vld,
   output logic      push_vld,
   output logic [7:0] push_data,
   output logic      term_vld,
   output pkt_code_e term_code
);
   localparam logic [OW-1:0] STUFF_V = OW'(STUFF_RUN);
   localparam logic [OW-1:0] FLAG_V  = OW'(STUFF_RUN + 1);
   localparam logic [OW-1:0] ABORT_V = OW'(STUFF_RUN + 2);

   logic          in_frame;
   logic [OW-1:0] ones;
   logic [2:0]    bitcnt;
   logic [7:0]    shreg, held_new, held_old;
   logic [1:0]    nb;
   logic [15:0]   crc_q, crc_upd;
   logic          is_abort, is_flag, is_data, byte_done;
   logic [7:0]    sh_nxt;

   always_comb begin
      is_abort  = bit_vld &  bit_in & (ones == ABORT_V - 1'b1);
      is_flag   = bit_vld & ~bit_in & (ones == FLAG_V);
      is_data   = bit_vld & in_frame & (ones < STUFF_V);
      sh_nxt    = {bit_in, shreg[7:1]};
      byte_done = is_data & (bitcnt == 3'd7);
   end

   hdlc_rx_crc16 #(.POLY(CRC_POLY_REF)) u_crc (
      .crc_in (crc_q),
      .data_in(sh_nxt),
      .crc_out(crc_upd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame  <= 1'b0;
         ones      <= '0;
         bitcnt    <= '0;
         shreg     <= '0;
         held_new  <= '0;
         held_old  <= '0;
         nb        <= '0;
         crc_q     <= CRC_PRESET;
         push_vld  <= 1'b0;
         push_data <= '0;
         term_vld  <= 1'b0;
         term_code <= PS_BUSY;
      end else begin
         push_vld <= 1'b0;
         term_vld <= 1'b0;
         if (clr) begin
            in_frame <= 1'b0;
            ones     <= '0;
            bitcnt   <= '0;
            nb       <= '0;
            crc_q    <= CRC_PRESET;
         end else begin
            if (bit_vld)
               ones <= bit_in ? ((ones == ABORT_V) ? ones : ones + 1'b1) : '0;
            if (is_abort) begin
               in_frame <= 1'b0;
               if (in_frame && nb != 2'd0) begin
                  term_vld  <= 1'b1;
                  term_code <= PS_ABORT;
               end
            end else if (is_flag) begin
               if (in_frame) begin
                  term_vld  <= 1'b1;
                  term_code <= (bitcnt == 3'd6 && nb == 2'd3) ?
                               ((crc_q == CRC_GOOD_RES) ? PS_GOOD : PS_CRCERR) : PS_BUSY;
               end
               in_frame <= 1'b1;
               bitcnt   <= '0;
               nb       <= '0;
               crc_q    <= CRC_PRESET;
            end else if (is_data) begin
               shreg  <= sh_nxt;
               bitcnt <= bitcnt + 3'd1;
               if (byte_done) begin
                  crc_q    <= crc_upd;
                  held_new <= sh_nxt;
                  held_old <= held_new;
                  if (nb[1]) begin
                     push_vld  <= 1'b1;
                     push_data <= held_old;
                  end
                  nb <= (nb == 2'd3) ? nb : nb + 2'd1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
   import hdlc_rx_pkg::*;
#(
   parameter int FIFO_DEPTH = 256,
   parameter int STUFF_RUN  = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             soft_rst,
   input  logic                             rx_bit,
   input  logic                             rx_bit_vld,
   input  logic                             rd_en,
   output logic [7:0]                       rd_data,
   output logic [7:0]                       avail_stat,
   output logic [2:0]                       pkt_status,
   input  logic                             stat_ack,
   input  logic [$clog2(FIFO_DEPTH+1)-1:0]  hwm_thr,
   input  logic                             hwm_ie,
   input  logic                             end_ie,
   output logic                             irq_hwm,
   output logic                             irq_end
);
   localparam int THR_W = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH < 4 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 4");
   end
   if (STUFF_RUN < 2) begin : g_bad_run
      $error("STUFF_RUN must be at least 2");
   end

   logic             push_vld, term_vld, fifo_full;
   logic [7:0]       push_data;
   pkt_code_e        term_code, code_q;
   logic             pend_q, ovf_seen;
   logic [THR_W-1:0] level;
   logic [6:0]       cnt7;

   hdlc_rx_deframer #(.STUFF_RUN(STUFF_RUN)) u_deframer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_rst),
      .bit_in   (rx_bit),
      .bit_vld  (rx_bit_vld),
      .push_vld (push_vld),
      .push_data(push_data),
      .term_vld (term_vld),
      .term_code(term_code)
   );

   hdlc_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (soft_rst),
      .wr_en  (push_vld),
      .wr_data(push_data),
      .rd_en  (rd_en),
      .rd_data(rd_data),
      .level  (level),
      .full   (fifo_full)
   );

   if (THR_W > 7) begin : g_sat
      assign cnt7 = (level > THR_W'(127)) ? 7'd127 : level[6:0];
   end else begin : g_narrow
      assign cnt7 = 7'(level);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         code_q   <= PS_BUSY;
         ovf_seen <= 1'b0;
      end else if (soft_rst) begin
         pend_q   <= 1'b0;
         code_q   <= PS_BUSY;
         ovf_seen <= 1'b0;
      end else begin
         if (push_vld && fifo_full) ovf_seen <= 1'b1;
         if (term_vld) begin
            ovf_seen <= 1'b0;
            if (term_code != PS_BUSY) begin
               pend_q <= 1'b1;
               code_q <= ovf_seen ? PS_OVF : term_code;
            end
         end else if (stat_ack) begin
            pend_q <= 1'b0;
            code_q <= PS_BUSY;
         end
      end
   end

   assign avail_stat = {pend_q, cnt7};
   assign pkt_status = code_q;
   assign irq_hwm    = hwm_ie & (hwm_thr != '0) & (level >= hwm_thr);
   assign irq_end    = end_ie & pend_q;
endmodule

// File: rtl/hdlc_rx_ctrl_chk.sv
module hdlc_rx_ctrl_chk #(
   parameter int TW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          soft_rst,
   input logic [7:0]    avail_stat,
   input logic [2:0]    pkt_status,
   input logic [TW-1:0] hwm_thr,
   input logic          irq_hwm,
   input logic          irq_end
);
   a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_status <= 3'd4);

   a_r6_pend_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
      avail_stat[7] == (pkt_status != 3'd0));

   a_r12_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (avail_stat == 8'd0 && pkt_status == 3'd0));

   a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(soft_rst) ||
      avail_stat[6:0] == $past(avail_stat[6:0]) ||
      avail_stat[6:0] == $past(avail_stat[6:0]) + 7'd1 ||
      avail_stat[6:0] + 7'd1 == $past(avail_stat[6:0]));

   a_r10_hwm_level: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_hwm && 32'(hwm_thr) <= 32'd127) |-> 32'(avail_stat[6:0]) >= 32'(hwm_thr));

   a_r11_end_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq_end |-> avail_stat[7]);
endmodule

bind hdlc_rx_ctrl hdlc_rx_ctrl_chk #(.TW(THR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .soft_rst  (soft_rst),
   .avail_stat(avail_stat),
   .pkt_status(pkt_status),
   .hwm_thr   (hwm_thr),
   .irq_hwm   (irq_hwm),
   .irq_end   (irq_end)
);

// File: tb/tb_hdlc_rx_ctrl.sv
`timescale 1ns/1ps
module tb_hdlc_rx_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       rx_bit = 1'b0;
   logic       rx_bit_vld = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [7:0] avail_stat;
   logic [2:0] pkt_status;
   logic       stat_ack = 1'b0;
   logic [8:0] hwm_thr = 9'd0;
   logic       hwm_ie = 1'b0;
   logic       end_ie = 1'b0;
   logic       irq_hwm, irq_end;

   int checks = 0;
   int errors = 0;
   int ones_run = 0;
   logic [7:0] pay [0:299];

   always #4 clk = ~clk;

   hdlc_rx_ctrl #(.FIFO_DEPTH(256), .STUFF_RUN(5)) dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
      .rd_en(rd_en), .rd_data(rd_data),
      .avail_stat(avail_stat), .pkt_status(pkt_status), .stat_ack(stat_ack),
      .hwm_thr(hwm_thr), .hwm_ie(hwm_ie), .end_ie(end_ie),
      .irq_hwm(irq_hwm), .irq_end(irq_end)
   );

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send_raw(input logic b);
      rx_bit = b;
      rx_bit_vld = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      rx_bit_vld = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_flag();
      send_raw(1'b0);
      for (int i = 0; i < 6; i++) send_raw(1'b1);
      send_raw(1'b0);
      ones_run = 0;
   endtask

   task automatic send_abort();
      for (int i = 0; i < 8; i++) send_raw(1'b1);
   endtask

   task automatic send_octet(input logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         send_raw(b[i]);
         if (b[i]) begin
            ones_run++;
            if (ones_run == 5) begin
               send_raw(1'b0);
               ones_run = 0;
            end
         end else ones_run = 0;
      end
   endtask

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
         else             r = r >> 1;
      end
      return r;
   endfunction

   task automatic send_frame(input int len, input logic corrupt);
      logic [15:0] c;
      logic [15:0] fcs;
      c = 16'hFFFF;
      send_flag();
      for (int i = 0; i < len; i++) begin
         send_octet(pay[i]);
         c = crc_step(c, pay[i]);
      end
      fcs = ~c ^ {15'd0, corrupt};
      send_octet(fcs[7:0]);
      send_octet(fcs[15:8]);
      send_flag();
      idle(4);
   endtask

   task automatic drain(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         check(req, int'(rd_data), int'(pay[i]));
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic ack();
      stat_ack = 1'b1;
      @(negedge clk);
      stat_ack = 1'b0;
      @(negedge clk);
   endtask

   task automatic fill_pay(input int seed);
      for (int i = 0; i < 300; i++) pay[i] = 8'(i * 37 + seed);
   endtask

   task automatic t_reset();
      check("R5 count after reset", int'(avail_stat), 0);
      check("R6 code after reset", int'(pkt_status), 0);
      check("R11 irq_end after reset", int'(irq_end), 0);
   endtask

   task automatic t_good();
      pay[0] = 8'h7E; pay[1] = 8'hFF; pay[2] = 8'h3C; pay[3] = 8'h00; pay[4] = 8'hF8;
      end_ie = 1'b1;
      send_frame(5, 1'b0);
      check("R3 good code", int'(pkt_status), 1);
      check("R5 pending bit", int'(avail_stat[7]), 1);
      check("R5 count good frame", int'(avail_stat[6:0]), 5);
      check("R11 irq_end enabled", int'(irq_end), 1);
      drain("R2 R4 destuffed payload", 5);
      check("R4 empty after drain", int'(avail_stat[6:0]), 0);
      ack();
      check("R6 ack clears code", int'(pkt_status), 0);
      check("R6 ack clears pending", int'(avail_stat[7]), 0);
   endtask

   task automatic t_crcerr();
      fill_pay(11);
      send_frame(4, 1'b1);
      check("R3 crc error code", int'(pkt_status), 2);
      check("R3 bytes stored on crc error", int'(avail_stat[6:0]), 4);
      drain("R4 crc error payload", 4);
      ack();
   endtask

   task automatic t_abort();
      fill_pay(3);
      send_flag();
      send_octet(pay[0]);
      send_octet(pay[1]);
      send_abort();
      idle(4);
      check("R7 abort code", int'(pkt_status), 3);
      check("R7 no bytes after abort", int'(avail_stat[6:0]), 0);
      for (int i = 0; i < 4; i++) send_octet(8'h55);
      idle(4);
      check("R7 bits ignored after abort count", int'(avail_stat[6:0]), 0);
      check("R7 bits ignored after abort code", int'(pkt_status), 3);
      ack();
   endtask

   task automatic t_short();
      fill_pay(9);
      send_frame(0, 1'b0);
      check("R9 fcs-only frame no pending", int'(avail_stat[7]), 0);
      check("R9 fcs-only frame no bytes", int'(avail_stat[6:0]), 0);
      send_flag();
      send_octet(8'hA5);
      send_flag();
      idle(4);
      check("R9 one-octet frame no pending", int'(avail_stat), 0);
   endtask

   task automatic t_hwm();
      fill_pay(21);
      hwm_thr = 9'd4;
      hwm_ie = 1'b1;
      end_ie = 1'b0;
      send_frame(6, 1'b0);
      check("R10 hwm above threshold", int'(irq_hwm), 1);
      check("R11 irq_end masked", int'(irq_end), 0);
      check("R1 frame closed pending", int'(avail_stat[7]), 1);
      hwm_ie = 1'b0;
      @(negedge clk);
      check("R10 hwm masked", int'(irq_hwm), 0);
      hwm_ie = 1'b1;
      drain("R4 hwm payload", 3);
      check("R10 hwm below threshold", int'(irq_hwm), 0);
      for (int i = 0; i < 3; i++) begin
         rd_en = 1'b1;
         @(negedge clk);
      end
      rd_en = 1'b0;
      hwm_ie = 1'b0;
      end_ie = 1'b1;
      ack();
   endtask

   task automatic t_saturate();
      fill_pay(5);
      send_frame(200, 1'b0);
      check("R5 count saturates", int'(avail_stat[6:0]), 127);
      check("R3 long good frame", int'(pkt_status), 1);
      drain("R4 long payload", 200);
      check("R5 count drained", int'(avail_stat[6:0]), 0);
      ack();
   endtask

   task automatic t_overflow();
      fill_pay(77);
      send_frame(260, 1'b0);
      check("R8 overflow code", int'(pkt_status), 4);
      check("R8 count at full", int'(avail_stat[6:0]), 127);
      check("R8 oldest kept", int'(rd_data), int'(pay[0]));
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      check("R12 soft reset count", int'(avail_stat), 0);
      check("R12 soft reset code", int'(pkt_status), 0);
      check("R12 soft reset irq_end", int'(irq_end), 0);
      fill_pay(40);
      send_frame(3, 1'b0);
      check("R12 receives after soft reset", int'(pkt_status), 1);
      drain("R12 payload after soft reset", 3);
      ack();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_good();
      t_crcerr();
      t_abort();
      t_short();
      t_hwm();
      t_saturate();
      t_overflow();
      finish_run();
   end
endmodule